// File: doc/BRIEF.md
# Rotate Through Carry Unit

This block rotates a data word together with a carry flag, treating the carry as one extra bit on top of the word. The word and the carry together form a ring one bit wider than the data. A left rotate moves every ring bit toward the more significant end, and the top data bit passes into the carry. A right rotate moves bits the other way, and the lowest data bit passes into the carry. A count of any value from zero up to one less than the data width is carried out in a single operation, not one bit per cycle.

The count input may be wider than needed. Only its low bits are used: enough of them to cover the data width, which is five bits at the default width of 32. A masked count of zero passes the word through untouched and keeps the incoming carry.

The result can be taken combinationally or from an output register, chosen by a parameter. The register loads on a valid strobe and is cleared by a synchronous, active-high reset.

Top module: `rcu_rotate_carry`

## Requirements
- R1: Only bits [4:0] of `count_i` set the rotate amount. Bits [7:5] have no effect on the result or on the carry.
- R2: When the masked count is 0, `result_o` equals `src_i` and `carry_o` equals `carry_i`.
- R3: With `dir_i` = 0 (left) and masked count n in 1..31, `{carry_o, result_o}` is the 33-bit value `{carry_i, src_i}` rotated left by n. So `carry_i` appears at result bit n-1, and `carry_o` is source bit 32-n.
- R4: With `dir_i` = 1 (right) and masked count n in 1..31, `{carry_o, result_o}` is `{carry_i, src_i}` rotated right by n. So `carry_i` appears at result bit 32-n, and `carry_o` is source bit n-1.
- R5: At a count of 1, a left rotate gives `{src_i[30:0], carry_i}` with carry `src_i[31]`. A right rotate gives `{carry_i, src_i[31:1]}` with carry `src_i[0]`. No other bit wraps in.
- R6: At a count of 31, the extreme wrap positions are exact. A left rotate puts `carry_i` at bit 30 and takes the carry from source bit 1. A right rotate puts `carry_i` at bit 1 and takes the carry from source bit 30.
- R7: In the registered variant, the outputs take the new value at the first rising clock edge where `valid_i` is 1. They hold their value at every edge where `valid_i` is 0.
- R8: A synchronous active-high `rst` clears `result_o` and `carry_o` to 0, and it takes priority over `valid_i`.
- R9: The number of ones in `{carry_o, result_o}` equals the number of ones in the `{carry_i, src_i}` value that was loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Load strobe for the output register |
| dir_i | input | 1 | Rotate direction: 0 left, 1 right |
| count_i | input | 8 | Rotate amount; only bits [4:0] are used |
| src_i | input | 32 | Source data word |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Rotated data word |
| carry_o | output | 1 | Outgoing carry flag |

## Verification
The operands use a single set bit or a contiguous run of bits. Each such pattern sits where one particular wrap path takes it into or out of the carry, so a misplaced wrap shows up as a moved or a lost bit. Every count from 0 to 31 is applied in both directions with both carry values and random data, and the result is compared with a model that rotates one bit at a time. This separates off-by-one carry placement from errors in the wrap term. Counts with bits set above bit 4 must give the same result as their masked value, and the zero count must keep the incoming carry, which tells masking apart from plain truncation. Directed steps then confirm that the register holds while `valid_i` is low and that reset wins over `valid_i`.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
   typedef enum logic {
      ROT_LEFT  = 1'b0,
      ROT_RIGHT = 1'b1
   } rot_dir_e;

   function automatic int unsigned cnt_bits(input int unsigned data_w);
      return (data_w <= 1) ? 1 : $clog2(data_w);
   endfunction
endpackage

// File: rtl/rcu_count_mask.sv
module rcu_count_mask #(
   parameter int unsigned CNT_IN_W = 8,
   parameter int unsigned CNT_W    = 5
) (
   input  logic [CNT_IN_W-1:0] cnt_raw,
   output logic [CNT_W-1:0]    cnt_eff
);
   initial begin
      if (CNT_IN_W < CNT_W) $error("rcu_count_mask: count input narrower than needed");
   end

   assign cnt_eff = cnt_raw[CNT_W-1:0];

   generate
      if (CNT_IN_W > CNT_W) begin : g_drop_hi
         logic unused_hi_bits;
         assign unused_hi_bits = ^cnt_raw[CNT_IN_W-1:CNT_W];
      end
   endgenerate
endmodule

// File: rtl/rcu_ring_rotate.sv
module rcu_ring_rotate #(
   parameter int unsigned RING_W = 33,
   parameter int unsigned CNT_W  = 5
) (
   input  logic [RING_W-1:0] ring_in,
   input  logic [CNT_W-1:0]  cnt,
   input  rcu_pkg::rot_dir_e dir,
   output logic [RING_W-1:0] ring_out
);
   initial begin
      if ((1 << (CNT_W - 1)) >= RING_W) $error("rcu_ring_rotate: stage step exceeds ring");
   end

   logic [RING_W-1:0] stage [CNT_W+1];
   assign stage[0] = ring_in;

   // log-depth barrel: stage k rotates the ring by 2**k when cnt[k] is set
   generate
      for (genvar k = 0; k < CNT_W; k++) begin : g_stage
         localparam int unsigned STEP = 1 << k;
         logic [RING_W-1:0] rot_l, rot_r;
         assign rot_l = {stage[k][RING_W-1-STEP:0], stage[k][RING_W-1:RING_W-STEP]};
         assign rot_r = {stage[k][STEP-1:0], stage[k][RING_W-1:STEP]};
         always_comb begin
            if (!cnt[k])                      stage[k+1] = stage[k];
            else if (dir == rcu_pkg::ROT_LEFT) stage[k+1] = rot_l;
            else                              stage[k+1] = rot_r;
         end
      end
   endgenerate

   assign ring_out = stage[CNT_W];
endmodule

// File: rtl/rcu_out_stage.sv
module rcu_out_stage #(
   parameter int unsigned WIDTH      = 33,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)       q <= '0;
            else if (load) q <= d;
         end
      end else begin : g_comb
         logic unused_ctl;
         assign unused_ctl = clk ^ rst ^ load;
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/rcu_rotate_carry.sv
module rcu_rotate_carry #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_IN_W   = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                valid_i,
   input  logic                dir_i,
   input  logic [CNT_IN_W-1:0] count_i,
   input  logic [DATA_W-1:0]   src_i,
   input  logic                carry_i,
   output logic [DATA_W-1:0]   result_o,
   output logic                carry_o
);
   localparam int unsigned CNT_W  = rcu_pkg::cnt_bits(DATA_W);
   localparam int unsigned RING_W = DATA_W + 1;

   initial begin
      if (DATA_W < 2)        $error("rcu_rotate_carry: DATA_W must be at least 2");
      if (CNT_IN_W < CNT_W)  $error("rcu_rotate_carry: CNT_IN_W too small");
   end

   logic [CNT_W-1:0]  cnt_eff;
   logic [RING_W-1:0] ring_in, ring_rot, ring_q;
   rcu_pkg::rot_dir_e dir;

   assign dir     = rcu_pkg::rot_dir_e'(dir_i);
   assign ring_in = {carry_i, src_i};

   rcu_count_mask #(.CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W)) u_mask (
      .cnt_raw (count_i),
      .cnt_eff (cnt_eff)
   );

   rcu_ring_rotate #(.RING_W(RING_W), .CNT_W(CNT_W)) u_rot (
      .ring_in  (ring_in),
      .cnt      (cnt_eff),
      .dir      (dir),
      .ring_out (ring_rot)
   );

   rcu_out_stage #(.WIDTH(RING_W), .REGISTERED(REGISTERED)) u_out (
      .clk  (clk),
      .rst  (rst),
      .load (valid_i),
      .d    (ring_rot),
      .q    (ring_q)
   );

   assign carry_o  = ring_q[RING_W-1];
   assign result_o = ring_q[DATA_W-1:0];
endmodule

// File: rtl/rcu_rotate_carry_chk.sv
module rcu_rotate_carry_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_IN_W   = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input logic                clk,
   input logic                rst,
   input logic                valid_i,
   input logic                dir_i,
   input logic [CNT_IN_W-1:0] count_i,
   input logic [DATA_W-1:0]   src_i,
   input logic                carry_i,
   input logic [DATA_W-1:0]   result_o,
   input logic                carry_o
);
   localparam int unsigned CW = rcu_pkg::cnt_bits(DATA_W);

   generate
      if (REGISTERED) begin : g_seq
         assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !valid_i |=> ($stable(result_o) && $stable(carry_o)));

         assert_zero_count_R2: assert property (@(posedge clk) disable iff (rst)
            (valid_i && count_i[CW-1:0] == '0) |=>
               (result_o == $past(src_i) && carry_o == $past(carry_i)));

         assert_left_one_R5: assert property (@(posedge clk) disable iff (rst)
            (valid_i && !dir_i && count_i[CW-1:0] == CW'(1)) |=>
               ({carry_o, result_o} == {$past(src_i), $past(carry_i)}));

         assert_right_one_R5: assert property (@(posedge clk) disable iff (rst)
            (valid_i && dir_i && count_i[CW-1:0] == CW'(1)) |=>
               ({carry_o, result_o} ==
                {$past(src_i[0]), $past(carry_i), $past(src_i[DATA_W-1:1])}));

         assert_popcount_R9: assert property (@(posedge clk) disable iff (rst)
            valid_i |=> ($countones({carry_o, result_o}) ==
                         $past($countones({carry_i, src_i}))));
      end else begin : g_comb
         always_comb begin
            if (!$isunknown({carry_i, src_i, count_i, dir_i})) begin
               assert_popcount_R9: assert ($countones({carry_o, result_o}) ==
                                           $countones({carry_i, src_i}));
            end
         end
      end
   endgenerate
endmodule

bind rcu_rotate_carry rcu_rotate_carry_chk #(
   .DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W), .REGISTERED(REGISTERED)
) u_chk (
   .clk(clk), .rst(rst), .valid_i(valid_i), .dir_i(dir_i), .count_i(count_i),
   .src_i(src_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
);

// File: tb/test_rcu_rotate_carry.sv
`timescale 1ns/1ps
module test_rcu_rotate_carry;
   localparam int NVEC = 10;
   // {dir, count[7:0], carry_in, src[31:0], exp_result[31:0], exp_carry}
   localparam logic [74:0] VEC [NVEC] = '{
      {1'b0, 8'd1,  1'b1, 32'h8000_0000, 32'h0000_0001, 1'b1},  // R5 left
      {1'b1, 8'd1,  1'b1, 32'h0000_0001, 32'h8000_0000, 1'b1},  // R5 right
      {1'b0, 8'd0,  1'b1, 32'h1234_5678, 32'h1234_5678, 1'b1},  // R2
      {1'b0, 8'd32, 1'b0, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0},  // R1 masks to 0
      {1'b0, 8'd33, 1'b0, 32'h0000_0001, 32'h0000_0002, 1'b0},  // R1 masks to 1
      {1'b1, 8'd31, 1'b0, 32'h0000_0001, 32'h0000_0004, 1'b0},  // R6 right
      {1'b0, 8'd31, 1'b1, 32'h0000_0000, 32'h4000_0000, 1'b0},  // R6 left
      {1'b1, 8'd16, 1'b1, 32'hFFFF_0000, 32'h0001_FFFF, 1'b0},  // R4
      {1'b0, 8'd8,  1'b0, 32'h0000_00FF, 32'h0000_FF00, 1'b0},  // R3
      {1'b0, 8'd4,  1'b0, 32'hF000_0000, 32'h0000_0007, 1'b1}   // R3
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        valid_i;
   logic        dir_i;
   logic [7:0]  count_i;
   logic [31:0] src_i;
   logic        carry_i;
   logic [31:0] result_o;
   logic        carry_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   rcu_rotate_carry i_rcu_rotate_carry (
      .clk(clk), .rst(rst), .valid_i(valid_i), .dir_i(dir_i), .count_i(count_i),
      .src_i(src_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
   );

   function automatic logic [32:0] ref_rot(input logic d, input logic [7:0] c,
                                           input logic ci, input logic [31:0] s);
      logic [32:0] ring = {ci, s};
      for (int i = 0; i < int'(c[4:0]); i++)
         ring = d ? {ring[0], ring[32:1]} : {ring[31:0], ring[32]};
      return ring;
   endfunction

   task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got carry=%0b result=%08h, expected carry=%0b result=%08h",
                  tag, got[32], got[31:0], exp[32], exp[31:0]);
      end
   endtask

   task automatic apply(input logic d, input logic [7:0] c, input logic ci,
                        input logic [31:0] s);
      @(negedge clk);
      dir_i = d; count_i = c; carry_i = ci; src_i = s; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; valid_i = 1'b0; dir_i = 1'b0; count_i = '0; carry_i = 1'b0; src_i = '0;
      repeat (3) @(negedge clk);
      check("R8 reset state", {carry_o, result_o}, 33'd0);
      rst = 1'b0;

      // table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         apply(VEC[v][74], VEC[v][73:66], VEC[v][65], VEC[v][64:33]);
         check($sformatf("R3/R4 table vector %0d", v), {carry_o, result_o},
               {VEC[v][0], VEC[v][32:1]});
      end

      // every count, both directions, both carry values: R3 R4 R9
      for (int d = 0; d < 2; d++)
         for (int ci = 0; ci < 2; ci++)
            for (int c = 0; c < 32; c++) begin
               logic [31:0] s = $urandom;
               apply(d[0], 8'(c), ci[0], s);
               check(d ? "R4 sweep" : "R3 sweep", {carry_o, result_o},
                     ref_rot(d[0], 8'(c), ci[0], s));
               if ($countones({carry_o, result_o}) != $countones({ci[0], s})) begin
                  n_checks++; n_fail++;
                  $display("FAIL R9: got ones=%0d expected ones=%0d",
                           $countones({carry_o, result_o}), $countones({ci[0], s}));
               end else n_checks++;
            end

      // high count bits ignored: R1
      for (int i = 0; i < 16; i++) begin
         logic [7:0]  c = 8'($urandom);
         logic [31:0] s = $urandom;
         logic        d = 1'($urandom);
         logic        ci = 1'($urandom);
         apply(d, c, ci, s);
         check("R1 high count bits", {carry_o, result_o}, ref_rot(d, {3'b000, c[4:0]}, ci, s));
      end

      // R6 extreme with all ones data and carry clear
      apply(1'b0, 8'd31, 1'b0, 32'hFFFF_FFFF);
      check("R6 left 31", {carry_o, result_o}, {1'b1, 32'hBFFF_FFFF});
      apply(1'b1, 8'd31, 1'b0, 32'hFFFF_FFFF);
      check("R6 right 31", {carry_o, result_o}, {1'b1, 32'hFFFF_FFFD});

      // hold while valid low: R7
      apply(1'b0, 8'd3, 1'b1, 32'h0000_0011);
      @(negedge clk);
      dir_i = 1'b1; count_i = 8'd7; carry_i = 1'b0; src_i = 32'hDEAD_BEEF; valid_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 hold without valid", {carry_o, result_o}, {1'b0, 32'h0000_008C});

      // reset wins over valid: R8
      @(negedge clk);
      rst = 1'b1; valid_i = 1'b1;
      @(negedge clk);
      check("R8 reset priority", {carry_o, result_o}, 33'd0);
      rst = 1'b0; valid_i = 1'b0;

      finish_run();
   end
endmodule